// File: doc/BRIEF.md
# Dual-Tag Snooping Cache Controller

This block is the tag and control core of a direct-mapped processor cache that lives on a system bus shared with DMA masters. It holds two tag stores with identical contents. The processor store answers the processor's read lookups. The shadow store compares each DMA write address while the bus is granted away from the processor. Any fill writes the same entry into both stores. Any invalidate clears the same entry in both stores.

Because DMA writes are compared against the shadow copy, the processor keeps running out of the cache for the whole grant. It stalls only when a DMA write lands on a line that is currently cached. When that happens the controller takes the internal bus and emits an invalidate for the matching index. It raises a one-cycle stall to the processor, and it keeps checking the DMA writes that follow. A line's data sits in a plain register array, which is written by the fill port after a miss.

Top module: `dual_tag_cache`

## Requirements
- R1: An address splits into a 9-bit label in its top bits, then IDX_W index bits (default 8), then OFF_W offset bits at the bottom (default 1), which are ignored. A lookup is accepted when cpu_req is high and cpu_stall is low. It is answered on the next cycle with exactly one of cpu_hit and cpu_miss. On a hit, cpu_rdata holds the line's data.
- R2: A lookup hits only if all three hold: the entry is valid, its stored label equals the address label, and its stored parity bit is consistent. Otherwise it misses.
- R3: A fill (fill_we) writes the label, the parity bit and valid=1 into both tag stores, and writes the data into the data array. A later lookup with the same label and index hits and returns that data. A different label at that index misses.
- R4: The stored parity bit makes the total number of ones across the label and the parity bit even. With fill_bad_par high, the stored parity bit is inverted. A lookup of that line then misses, and a refill with good parity makes it hit again.
- R5: A DMA write hits the shadow store when dma_grant, dma_cyc and dma_wr are all high and the shadow entry is valid with a matching label. On that cycle inv_fire is high and inv_index equals the address index, and the entry becomes invalid in both stores. Later lookups of that line miss, and a repeat DMA write to it does not fire.
- R6: A granted DMA write that misses the shadow store neither stalls the processor nor disturbs any line, so processor lookups keep hitting.
- R7: cpu_stall is high in exactly the cycle after each inv_fire cycle and low at all other times. Back-to-back snoop hits keep it high without a gap.
- R8: A cpu_req presented while cpu_stall is high is ignored: neither cpu_hit nor cpu_miss rises on the next cycle.
- R9: A DMA read (dma_wr low), or a DMA write made without dma_grant, never invalidates a line and never stalls.
- R10: When a fill and an invalidate target the same index in the same cycle, the invalidate wins and the entry is invalid afterwards.
- R11: A lookup made in the same cycle as an invalidate of its index reports a miss.
- R12: Reset clears every valid bit and drives cpu_hit, cpu_miss and cpu_stall low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor read lookup strobe |
| cpu_addr | input | ADDR_W | Processor physical address |
| cpu_hit | output | 1 | Lookup hit, one cycle after the request |
| cpu_miss | output | 1 | Lookup miss, one cycle after the request |
| cpu_rdata | output | DATA_W | Line data returned on a hit |
| cpu_stall | output | 1 | Stall request to the processor |
| fill_we | input | 1 | Line fill strobe |
| fill_addr | input | ADDR_W | Fill address |
| fill_data | input | DATA_W | Fill data |
| fill_bad_par | input | 1 | Stores an inverted parity bit for this fill |
| dma_grant | input | 1 | System bus granted to a DMA master |
| dma_cyc | input | 1 | DMA bus cycle active |
| dma_wr | input | 1 | DMA cycle is a write |
| dma_addr | input | ADDR_W | DMA physical address |
| inv_fire | output | 1 | Invalidate issued on the internal bus |
| inv_index | output | IDX_W | Index being invalidated |

## Verification
The bench first targets a fill that collides with an invalidate on the same index. If the fill won, a line holding stale data would survive the DMA write and later hit. It also checks a lookup that coincides with an invalidate of its own line, which a design that compared only the old tag state would report as a hit. Back-to-back snoop hits are run to catch a stall that drops between them or that lasts one cycle too long. A lookup issued during a stall is checked so that a design answering it shows up as a spurious hit or miss. Corrupted parity, DMA reads, ungranted writes and a byte-offset address each target a fault that would flip a hit or fire a false invalidate.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int LABEL_W    = 9;
    localparam int DEF_IDX_W  = 8;
    localparam int DEF_OFF_W  = 1;
    localparam int DEF_DATA_W = 16;

    typedef logic [LABEL_W-1:0] label_t;

    typedef struct packed {
        logic   valid;
        logic   par;
        label_t label;
    } tag_entry_t;

    // parity bit that makes the label plus the bit carry an even count of ones
    function automatic logic even_par(label_t l);
        return ^l;
    endfunction

    function automatic logic entry_ok(tag_entry_t e, label_t l);
        return e.valid && (e.label == l) && (e.par == even_par(e.label));
    endfunction

endpackage

// File: rtl/dtc_tag_store.sv
module dtc_tag_store
    import dtc_pkg::*;
#(
    parameter int IDX_W = DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output tag_entry_t       rd_entry,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tag_entry_t       wr_entry,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);
    localparam int DEPTH = 1 << IDX_W;

    tag_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (wr_en) begin
                mem[wr_idx] <= wr_entry;
            end
            // placed last so a same-index invalidate overrides the fill
            if (inv_en) begin
                mem[inv_idx].valid <= 1'b0;
            end
        end
    end

    assign rd_entry = mem[rd_idx];

endmodule

// File: rtl/dtc_data_array.sv
module dtc_data_array
    import dtc_pkg::*;
#(
    parameter int IDX_W  = DEF_IDX_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/dtc_snoop_ctl.sv
module dtc_snoop_ctl
    import dtc_pkg::*;
#(
    parameter int IDX_W = DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_grant,
    input  logic             dma_cyc,
    input  logic             dma_wr,
    input  label_t           dma_label,
    input  logic [IDX_W-1:0] dma_idx,
    input  tag_entry_t       shadow_entry,
    output logic             inv_en,
    output logic [IDX_W-1:0] inv_idx,
    output logic             stall
);
    logic dma_write;
    logic stall_q;

    assign dma_write = dma_grant && dma_cyc && dma_wr;
    assign inv_en    = dma_write && shadow_entry.valid && (shadow_entry.label == dma_label);
    assign inv_idx   = dma_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
        end else begin
            stall_q <= inv_en;
        end
    end

    assign stall = stall_q;

endmodule

// File: rtl/dtc_lookup_ctl.sv
module dtc_lookup_ctl
    import dtc_pkg::*;
#(
    parameter int IDX_W  = DEF_IDX_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              stall,
    input  label_t            label,
    input  logic [IDX_W-1:0]  idx,
    input  tag_entry_t        entry,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    output logic              hit,
    output logic              miss,
    output logic [DATA_W-1:0] rdata
);
    logic accept;
    logic match;

    assign accept = req && !stall;
    assign match  = entry_ok(entry, label) && !(inv_en && (inv_idx == idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            hit   <= 1'b0;
            miss  <= 1'b0;
            rdata <= '0;
        end else begin
            hit  <= accept && match;
            miss <= accept && !match;
            if (accept && match) begin
                rdata <= arr_data;
            end
        end
    end

endmodule

// File: rtl/dual_tag_cache.sv
module dual_tag_cache
    import dtc_pkg::*;
#(
    parameter  int IDX_W  = DEF_IDX_W,
    parameter  int OFF_W  = DEF_OFF_W,
    parameter  int DATA_W = DEF_DATA_W,
    localparam int ADDR_W = LABEL_W + IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_hit,
    output logic              cpu_miss,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_bad_par,
    input  logic              dma_grant,
    input  logic              dma_cyc,
    input  logic              dma_wr,
    input  logic [ADDR_W-1:0] dma_addr,
    output logic              inv_fire,
    output logic [IDX_W-1:0]  inv_index
);
    localparam int NSTORE = 2;   // 0: processor store, 1: shadow store

    label_t           cpu_label, fill_label, dma_label;
    logic [IDX_W-1:0] cpu_idx, fill_idx, dma_idx;
    tag_entry_t       fill_entry;
    logic [DATA_W-1:0] arr_data;
    logic             inv_en;
    logic [IDX_W-1:0] inv_idx;

    logic [IDX_W-1:0] rd_idx_a [NSTORE];
    tag_entry_t       rd_ent_a [NSTORE];

    logic unused_offset;
    assign unused_offset = ^{cpu_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], dma_addr[OFF_W-1:0]};

    assign cpu_label  = cpu_addr[ADDR_W-1 -: LABEL_W];
    assign fill_label = fill_addr[ADDR_W-1 -: LABEL_W];
    assign dma_label  = dma_addr[ADDR_W-1 -: LABEL_W];
    assign cpu_idx    = cpu_addr[OFF_W +: IDX_W];
    assign fill_idx   = fill_addr[OFF_W +: IDX_W];
    assign dma_idx    = dma_addr[OFF_W +: IDX_W];

    assign fill_entry = '{valid: 1'b1,
                          par:   even_par(fill_label) ^ fill_bad_par,
                          label: fill_label};

    assign rd_idx_a[0] = cpu_idx;
    assign rd_idx_a[1] = dma_idx;

    for (genvar g = 0; g < NSTORE; g++) begin : g_store
        dtc_tag_store #(.IDX_W(IDX_W)) u_store (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (rd_idx_a[g]),
            .rd_entry (rd_ent_a[g]),
            .wr_en    (fill_we),
            .wr_idx   (fill_idx),
            .wr_entry (fill_entry),
            .inv_en   (inv_en),
            .inv_idx  (inv_idx)
        );
    end

    dtc_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .we      (fill_we),
        .wr_idx  (fill_idx),
        .wr_data (fill_data),
        .rd_idx  (cpu_idx),
        .rd_data (arr_data)
    );

    dtc_snoop_ctl #(.IDX_W(IDX_W)) u_snoop (
        .clk          (clk),
        .rst          (rst),
        .dma_grant    (dma_grant),
        .dma_cyc      (dma_cyc),
        .dma_wr       (dma_wr),
        .dma_label    (dma_label),
        .dma_idx      (dma_idx),
        .shadow_entry (rd_ent_a[1]),
        .inv_en       (inv_en),
        .inv_idx      (inv_idx),
        .stall        (cpu_stall)
    );

    dtc_lookup_ctl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_lookup (
        .clk      (clk),
        .rst      (rst),
        .req      (cpu_req),
        .stall    (cpu_stall),
        .label    (cpu_label),
        .idx      (cpu_idx),
        .entry    (rd_ent_a[0]),
        .arr_data (arr_data),
        .inv_en   (inv_en),
        .inv_idx  (inv_idx),
        .hit      (cpu_hit),
        .miss     (cpu_miss),
        .rdata    (cpu_rdata)
    );

    assign inv_fire  = inv_en;
    assign inv_index = inv_idx;

endmodule

// File: rtl/dual_tag_cache_chk.sv
module dual_tag_cache_chk (
    input logic clk,
    input logic rst,
    input logic cpu_req,
    input logic cpu_hit,
    input logic cpu_miss,
    input logic cpu_stall,
    input logic dma_grant,
    input logic dma_cyc,
    input logic dma_wr,
    input logic inv_fire
);
    assert_single_answer_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_hit, cpu_miss}));

    assert_answer_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_stall) |=> (cpu_hit || cpu_miss));

    assert_stall_after_inv_R7: assert property (@(posedge clk) disable iff (rst)
        inv_fire |=> cpu_stall);

    assert_stall_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> $past(inv_fire));

    assert_stalled_req_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_stall) |=> !(cpu_hit || cpu_miss));

    assert_no_snoop_off_write_R9: assert property (@(posedge clk) disable iff (rst)
        !(dma_grant && dma_cyc && dma_wr) |-> !inv_fire);

endmodule

bind dual_tag_cache dual_tag_cache_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_hit   (cpu_hit),
    .cpu_miss  (cpu_miss),
    .cpu_stall (cpu_stall),
    .dma_grant (dma_grant),
    .dma_cyc   (dma_cyc),
    .dma_wr    (dma_wr),
    .inv_fire  (inv_fire)
);

// File: tb/test_dual_tag_cache.sv
module test_dual_tag_cache;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int IW = 8;

    localparam logic [1:0] OP_FILL = 2'd0;
    localparam logic [1:0] OP_LOOK = 2'd1;
    localparam logic [1:0] OP_DMA  = 2'd2;

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          expect_on;
    } vec_t;

    function automatic logic [AW-1:0] mk(int lbl, int idx);
        return AW'((lbl << 9) | (idx << 1));
    endfunction

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{OP_FILL, mk(5, 3),        16'hA5A5, 1'b0},  // R3 fill
        '{OP_LOOK, mk(5, 3),        16'hA5A5, 1'b1},  // R3 hit with data
        '{OP_LOOK, mk(6, 3),        16'h0000, 1'b0},  // R2 label mismatch
        '{OP_FILL, mk(7, 200),      16'h1234, 1'b0},  // R3 fill
        '{OP_LOOK, mk(7, 200),      16'h1234, 1'b1},  // R3 hit
        '{OP_LOOK, mk(7, 201),      16'h0000, 1'b0},  // R2 never-filled entry
        '{OP_LOOK, mk(7, 200) | 1,  16'h1234, 1'b1},  // R1 offset bit ignored
        '{OP_DMA,  mk(9, 3),        16'h0000, 1'b0},  // R6 snoop miss
        '{OP_LOOK, mk(5, 3),        16'hA5A5, 1'b1},  // R6 line survives
        '{OP_DMA,  mk(5, 3),        16'h0000, 1'b1},  // R5 snoop hit
        '{OP_LOOK, mk(5, 3),        16'h0000, 1'b0},  // R5 line gone
        '{OP_DMA,  mk(5, 3),        16'h0000, 1'b0},  // R5 shadow cleared too
        '{OP_FILL, mk(5, 3),        16'hBEEF, 1'b0},  // R3 refill
        '{OP_LOOK, mk(5, 3),        16'hBEEF, 1'b1}   // R3 new data
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_hit, cpu_miss, cpu_stall;
    logic [DW-1:0] cpu_rdata;
    logic          fill_we = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          fill_bad_par = 1'b0;
    logic          dma_grant = 1'b0, dma_cyc = 1'b0, dma_wr = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic          inv_fire;
    logic [IW-1:0] inv_index;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dual_tag_cache i_dual_tag_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_hit(cpu_hit), .cpu_miss(cpu_miss), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data), .fill_bad_par(fill_bad_par),
        .dma_grant(dma_grant), .dma_cyc(dma_cyc), .dma_wr(dma_wr), .dma_addr(dma_addr),
        .inv_fire(inv_fire), .inv_index(inv_index)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic badp);
        @(negedge clk);
        fill_we = 1'b1; fill_addr = a; fill_data = d; fill_bad_par = badp;
        @(negedge clk);
        fill_we = 1'b0; fill_bad_par = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a, input logic exp_hit, input logic [DW-1:0] exp_d, input string rq);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cpu_hit == exp_hit && cpu_miss == !exp_hit, rq, "hit", int'(cpu_hit), int'(exp_hit));
        if (exp_hit) chk(cpu_rdata == exp_d, rq, "rdata", int'(cpu_rdata), int'(exp_d));
    endtask

    task automatic dma(input logic [AW-1:0] a, input logic g, input logic w, input logic exp_fire, input string rq);
        @(negedge clk);
        dma_grant = g; dma_cyc = 1'b1; dma_wr = w; dma_addr = a;
        #1;
        chk(inv_fire == exp_fire, rq, "inv_fire", int'(inv_fire), int'(exp_fire));
        if (exp_fire) chk(inv_index == a[IW:1], rq, "inv_index", int'(inv_index), int'(a[IW:1]));
        @(negedge clk);
        dma_grant = 1'b0; dma_cyc = 1'b0; dma_wr = 1'b0;
        chk(cpu_stall == exp_fire, rq, "stall", int'(cpu_stall), int'(exp_fire));
        @(negedge clk);
        chk(cpu_stall == 1'b0, rq, "stall release", int'(cpu_stall), 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(!cpu_hit && !cpu_miss && !cpu_stall, "R12", "outputs after reset",
            int'({cpu_hit, cpu_miss, cpu_stall}), 0);
        look(mk(5, 3), 1'b0, '0, "R12");

        for (int k = 0; k < NVEC; k++) begin
            case (VEC[k].op)
                OP_FILL: do_fill(VEC[k].addr, VEC[k].data, 1'b0);
                OP_LOOK: look(VEC[k].addr, VEC[k].expect_on, VEC[k].data, "vector");
                default: dma(VEC[k].addr, 1'b1, 1'b1, VEC[k].expect_on, "vector");
            endcase
        end

        // R4: corrupted parity forces a miss, good refill recovers
        do_fill(mk(1, 10), 16'h1111, 1'b1);
        look(mk(1, 10), 1'b0, '0, "R4");
        do_fill(mk(1, 10), 16'h2222, 1'b0);
        look(mk(1, 10), 1'b1, 16'h2222, "R4");

        // R7 / R8: stall timing and a lookup dropped while stalled
        do_fill(mk(2, 20), 16'h0202, 1'b0);
        @(negedge clk);
        dma_grant = 1'b1; dma_cyc = 1'b1; dma_wr = 1'b1; dma_addr = mk(2, 20);
        #1 chk(inv_fire == 1'b1, "R7", "inv_fire", int'(inv_fire), 1);
        @(negedge clk);
        dma_grant = 1'b0; dma_cyc = 1'b0; dma_wr = 1'b0;
        cpu_req = 1'b1; cpu_addr = mk(7, 200);
        chk(cpu_stall == 1'b1, "R7", "stall raised", int'(cpu_stall), 1);
        @(negedge clk);
        cpu_req = 1'b0;
        chk(!cpu_hit && !cpu_miss, "R8", "stalled request answered",
            int'({cpu_hit, cpu_miss}), 0);
        chk(cpu_stall == 1'b0, "R7", "stall single cycle", int'(cpu_stall), 0);

        // R7: back-to-back snoop hits hold the stall without a gap
        do_fill(mk(3, 30), 16'h0303, 1'b0);
        do_fill(mk(4, 40), 16'h0404, 1'b0);
        @(negedge clk);
        dma_grant = 1'b1; dma_cyc = 1'b1; dma_wr = 1'b1; dma_addr = mk(3, 30);
        @(negedge clk);
        dma_addr = mk(4, 40);
        #1 chk(inv_fire == 1'b1, "R7", "second inv_fire", int'(inv_fire), 1);
        chk(cpu_stall == 1'b1, "R7", "stall first", int'(cpu_stall), 1);
        @(negedge clk);
        dma_grant = 1'b0; dma_cyc = 1'b0; dma_wr = 1'b0;
        chk(cpu_stall == 1'b1, "R7", "stall second", int'(cpu_stall), 1);
        @(negedge clk);
        chk(cpu_stall == 1'b0, "R7", "stall release", int'(cpu_stall), 0);
        look(mk(4, 40), 1'b0, '0, "R5");

        // R9: DMA read and ungranted write leave the line alone
        do_fill(mk(8, 50), 16'h0808, 1'b0);
        dma(mk(8, 50), 1'b1, 1'b0, 1'b0, "R9");
        dma(mk(8, 50), 1'b0, 1'b1, 1'b0, "R9");
        look(mk(8, 50), 1'b1, 16'h0808, "R9");

        // R10: fill and invalidate on one index in one cycle
        do_fill(mk(10, 60), 16'h0A0A, 1'b0);
        @(negedge clk);
        fill_we = 1'b1; fill_addr = mk(11, 60); fill_data = 16'h0B0B;
        dma_grant = 1'b1; dma_cyc = 1'b1; dma_wr = 1'b1; dma_addr = mk(10, 60);
        #1 chk(inv_fire == 1'b1, "R10", "inv_fire", int'(inv_fire), 1);
        @(negedge clk);
        fill_we = 1'b0; dma_grant = 1'b0; dma_cyc = 1'b0; dma_wr = 1'b0;
        look(mk(11, 60), 1'b0, '0, "R10");
        look(mk(10, 60), 1'b0, '0, "R10");

        // R11: lookup coinciding with invalidate of its line
        do_fill(mk(12, 70), 16'h0C0C, 1'b0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = mk(12, 70);
        dma_grant = 1'b1; dma_cyc = 1'b1; dma_wr = 1'b1; dma_addr = mk(12, 70);
        @(negedge clk);
        cpu_req = 1'b0; dma_grant = 1'b0; dma_cyc = 1'b0; dma_wr = 1'b0;
        chk(cpu_miss == 1'b1 && cpu_hit == 1'b0, "R11", "miss", int'(cpu_miss), 1);
        @(negedge clk);

        // R12: reset mid-run drops every line
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        look(mk(7, 200), 1'b0, '0, "R12");

        finish_run();
    end
endmodule